// File: doc/BRIEF.md
# Two-Way Granule Address Interleaver

This block sits between one upstream requester and three downstream memory ports. Each request is a single address carried by a valid/ready handshake. When interleaving is switched on and the address falls inside the striped window, the request goes to one of two striped ports. The choice comes from one address bit, so consecutive 4 KiB granules alternate between port 1 and port 2. Any other request goes to port 0. The address is forwarded unchanged.

Interleaving is switched on by sixteen independent enable lines. Each line drives its own bit of a registered enable mask. The interleave path is live while any mask bit is set. Each striped port has its own validity window. If the two windows disagree about an address, that is a configuration error: the request is sent to port 0 and an error flag is raised.

Two named states control the flow. `ST_IDLE` accepts a request (transition *accept*: `up_valid` high while `up_ready` is high). `ST_HOLD` presents the captured request on the selected port until that port is ready (transition *release*: the selected `down_ready` bit is high, back to `ST_IDLE`). No other transitions exist.

Top module: `granule_router`

## Requirements
- R1: After reset the block is in `ST_IDLE`: `up_ready` = 1, `down_valid` = 0, `cfg_err` = 0, and the enable mask is all zero.
- R2: With interleaving enabled and the address in both windows, address bit 12 clear routes to port 1 (`route_port` = 1, `down_valid` = 3'b010).
- R3: With interleaving enabled and the address in both windows, address bit 12 set routes to port 2 (`route_port` = 2, `down_valid` = 3'b100).
- R4: An address outside the striped window routes to port 0 (`route_port` = 0, `down_valid` = 3'b001).
- R5: `down_addr` equals the accepted upstream address exactly.
- R6: With the enable mask all zero, every request goes to port 0, including addresses inside the window.
- R7: Each enable line sets or clears only its own mask bit, one cycle after the line changes. Any single line high, lowest or highest, enables interleaving.
- R8: `route_mask` always equals granule size minus one (0xFFF).
- R9: An accepted request holds `down_valid`, `down_addr`, `route_port` and `cfg_err` steady until the selected port's `down_ready` is high. Ready from the ports that were not selected has no effect.
- R10: With interleaving enabled, an address valid for one striped window but not the other routes to port 0 with `cfg_err` = 1.
- R11: At most one `down_valid` bit is high. `up_ready` is high only in `ST_IDLE`, never while a request is held.
- R12: The window includes its base and excludes its limit: base is striped, while base-1 and limit go to port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_lines | input | 16 | Independent interleave enable lines |
| up_valid | input | 1 | Upstream request valid |
| up_addr | input | ADDR_W | Upstream request address |
| up_ready | output | 1 | Block can accept a request |
| down_valid | output | 3 | One-hot valid toward ports 0..2 |
| down_addr | output | ADDR_W | Address forwarded to the selected port |
| down_ready | input | 3 | Ready from ports 0..2 |
| route_port | output | 2 | Index of the selected port |
| route_mask | output | ADDR_W | Span covered by one decision (granule-1) |
| cfg_err | output | 1 | The two striped windows disagreed on the held request |

## Verification
The assertions check on every cycle that `down_valid` is one-hot or zero and never overlaps `up_ready`. They also check that a held request stays stable until its own port is ready, that the forwarded address matches the accepted one, that a striped index always equals one plus bit 12, and that an error flag always comes with port 0. Only the bench scenarios can show the rest: the window edges, the one-cycle delay of each enable line into the mask, fallback with all lines low, and the mismatch region created by deliberately unequal windows.

// File: rtl/gr_pkg.sv
package gr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } gr_state_e;

    localparam int NUM_PORTS = 3;
    localparam int PORT_W    = 2;

    typedef logic [PORT_W-1:0] port_idx_t;

    localparam port_idx_t PORT_BYPASS = 2'd0;
    localparam port_idx_t PORT_STRIPE0 = 2'd1;

endpackage

// File: rtl/gr_window_check.sv
module gr_window_check #(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] LIMIT = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Half-open window: base inclusive, limit exclusive.
    assign hit = (addr >= BASE) && (addr < LIMIT);
endmodule

// File: rtl/gr_enable_mask.sv
module gr_enable_mask #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    output logic               any_on
);
    logic [N_LINES-1:0] mask_q;

    // Each line owns exactly one mask bit and follows its level.
    for (genvar g = 0; g < N_LINES; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q[g] <= 1'b0;
            else        mask_q[g] <= lines[g];
        end
    end

    assign any_on = |mask_q;
endmodule

// File: rtl/gr_route_decide.sv
module gr_route_decide
    import gr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                GRAN_LOG = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h0001_0000,
    parameter logic [ADDR_W-1:0] WIN_LIMIT = 'h0002_0000,
    parameter logic [ADDR_W-1:0] ALT_BASE = WIN_BASE,
    parameter logic [ADDR_W-1:0] ALT_LIMIT = WIN_LIMIT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              striping_on,
    output port_idx_t         port,
    output logic              mismatch
);
    localparam int N_STRIPE = 2;
    logic [N_STRIPE-1:0] hit;

    // One window checker per striped target.
    for (genvar g = 0; g < N_STRIPE; g++) begin : g_win
        localparam logic [ADDR_W-1:0] B = (g == 0) ? WIN_BASE  : ALT_BASE;
        localparam logic [ADDR_W-1:0] L = (g == 0) ? WIN_LIMIT : ALT_LIMIT;
        gr_window_check #(.ADDR_W(ADDR_W), .BASE(B), .LIMIT(L)) u_win (
            .addr (addr),
            .hit  (hit[g])
        );
    end

    always_comb begin
        mismatch = striping_on && (hit[0] != hit[1]);
        if (striping_on && (&hit))
            port = PORT_STRIPE0 + port_idx_t'(addr[GRAN_LOG]);
        else
            port = PORT_BYPASS;
    end
endmodule

// File: rtl/gr_route_fsm.sv
module gr_route_fsm
    import gr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_valid,
    input  logic [ADDR_W-1:0]    up_addr,
    input  port_idx_t            dec_port,
    input  logic                 dec_err,
    input  logic [NUM_PORTS-1:0] down_ready,
    output logic                 up_ready,
    output logic [NUM_PORTS-1:0] down_valid,
    output logic [ADDR_W-1:0]    down_addr,
    output port_idx_t            route_port,
    output logic                 cfg_err
);
    gr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    port_idx_t         port_q;
    logic              err_q;
    logic              accept;
    logic              release_req;

    assign accept      = (state_q == ST_IDLE) && up_valid;
    assign release_req = (state_q == ST_HOLD) && down_ready[port_q];

    // State register and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            port_q  <= PORT_BYPASS;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= up_addr;
                port_q <= dec_port;
                err_q  <= dec_err;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d    = state_q;
        up_ready   = 1'b0;
        down_valid = '0;
        unique case (state_q)
            ST_IDLE: begin
                up_ready = 1'b1;
                if (accept) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                for (int i = 0; i < NUM_PORTS; i++)
                    down_valid[i] = (port_q == port_idx_t'(i));
                if (release_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        down_addr  = addr_q;
        route_port = port_q;
        cfg_err    = err_q && (state_q == ST_HOLD);
    end
endmodule

// File: rtl/granule_router.sv
module granule_router
    import gr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                GRAN_LOG = 12,
    parameter int                N_EN     = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h0001_0000,
    parameter logic [ADDR_W-1:0] WIN_LIMIT = 'h0002_0000,
    parameter logic [ADDR_W-1:0] ALT_BASE = WIN_BASE,
    parameter logic [ADDR_W-1:0] ALT_LIMIT = WIN_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       en_lines,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    output logic              up_ready,
    output logic [2:0]        down_valid,
    output logic [ADDR_W-1:0] down_addr,
    input  logic [2:0]        down_ready,
    output logic [1:0]        route_port,
    output logic [ADDR_W-1:0] route_mask,
    output logic              cfg_err
);
    localparam logic [ADDR_W-1:0] GRAN_MASK = (ADDR_W'(1) << GRAN_LOG) - ADDR_W'(1);

    logic      striping_on;
    port_idx_t dec_port;
    logic      dec_err;

    gr_enable_mask #(.N_LINES(N_EN)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (en_lines[N_EN-1:0]),
        .any_on (striping_on)
    );

    gr_route_decide #(
        .ADDR_W(ADDR_W), .GRAN_LOG(GRAN_LOG),
        .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT),
        .ALT_BASE(ALT_BASE), .ALT_LIMIT(ALT_LIMIT)
    ) u_decide (
        .addr        (up_addr),
        .striping_on (striping_on),
        .port        (dec_port),
        .mismatch    (dec_err)
    );

    gr_route_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (up_valid),
        .up_addr    (up_addr),
        .dec_port   (dec_port),
        .dec_err    (dec_err),
        .down_ready (down_ready),
        .up_ready   (up_ready),
        .down_valid (down_valid),
        .down_addr  (down_addr),
        .route_port (route_port),
        .cfg_err    (cfg_err)
    );

    assign route_mask = GRAN_MASK;
endmodule

// File: rtl/gr_checker.sv
module gr_checker #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LOG = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_ready,
    input logic [2:0]        down_valid,
    input logic [ADDR_W-1:0] down_addr,
    input logic [2:0]        down_ready,
    input logic [1:0]        route_port,
    input logic              cfg_err
);
    // R11
    onehot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(down_valid));

    // R11
    no_ready_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_ready && (|down_valid)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|down_valid) && !(|(down_valid & down_ready)))
        |=> ($stable(down_valid) && $stable(down_addr) && $stable(route_port) && $stable(cfg_err)));

    // R5
    addr_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> (down_addr == $past(up_addr)));

    // R2
    stripe_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|down_valid) && (route_port != 2'd0))
        |-> (route_port == (2'd1 + {1'b0, down_addr[GRAN_LOG]})));

    // R10
    err_goes_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (route_port == 2'd0 && down_valid == 3'b001));
endmodule

bind granule_router gr_checker #(.ADDR_W(ADDR_W), .GRAN_LOG(GRAN_LOG)) u_gr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (up_valid),
    .up_addr    (up_addr),
    .up_ready   (up_ready),
    .down_valid (down_valid),
    .down_addr  (down_addr),
    .down_ready (down_ready),
    .route_port (route_port),
    .cfg_err    (cfg_err)
);

// File: tb/test_granule_router.sv
module test_granule_router;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam logic [31:0] LIM  = 32'h0002_0000;
    localparam logic [31:0] ALIM = 32'h0001_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] en_lines = '0;
    logic        up_valid = 1'b0;
    logic [31:0] up_addr = '0;
    logic        up_ready;
    logic [2:0]  down_valid;
    logic [31:0] down_addr;
    logic [2:0]  down_ready = '0;
    logic [1:0]  route_port;
    logic [31:0] route_mask;
    logic        cfg_err;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    granule_router #(.ADDR_W(AW), .WIN_BASE(BASE), .WIN_LIMIT(LIM),
                     .ALT_LIMIT(ALIM)) i_granule_router (
        .clk(clk), .rst_n(rst_n), .en_lines(en_lines),
        .up_valid(up_valid), .up_addr(up_addr), .up_ready(up_ready),
        .down_valid(down_valid), .down_addr(down_addr), .down_ready(down_ready),
        .route_port(route_port), .route_mask(route_mask), .cfg_err(cfg_err)
    );

    typedef struct {
        logic [1:0]  port;
        logic [31:0] addr;
        logic        err;
        int          stall;
        string       req;
    } item_t;

    item_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: model expected route, push it, then offer the request.
    task automatic send(input logic [31:0] a, input int stall, input string req);
        item_t it;
        bit on  = |en_lines;
        bit inA = (a >= BASE) && (a < LIM);
        bit inB = (a >= BASE) && (a < ALIM);
        it.port  = (on && inA && inB) ? (2'd1 + {1'b0, a[12]}) : 2'd0;
        it.err   = on && (inA != inB);
        it.addr  = a;
        it.stall = stall;
        it.req   = req;
        @(negedge clk);
        while (!up_ready) @(negedge clk);
        sb.push_back(it);
        up_valid = 1'b1;
        up_addr  = a;
        @(negedge clk);
        up_valid = 1'b0;
        up_addr  = 32'hDEAD_BEEF;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each held request; release after its stall count.
    initial begin
        int left = -1;
        forever begin
            @(negedge clk);
            down_ready = '0;
            if (|down_valid) begin
                item_t it;
                logic [2:0] expv;
                if (sb.size() == 0) begin
                    check(0, "R11", "unexpected down_valid", {29'b0, down_valid}, 0);
                    continue;
                end
                it = sb[0];
                if (left < 0) left = it.stall;
                expv = 3'b001 << it.port;
                check(route_port == it.port, it.req, "route_port", {30'b0, route_port}, {30'b0, it.port});
                check(down_valid == expv, it.req, "down_valid", {29'b0, down_valid}, {29'b0, expv});
                check(down_addr == it.addr, "R5", "down_addr", down_addr, it.addr);
                check(cfg_err == it.err, "R10", "cfg_err", {31'b0, cfg_err}, {31'b0, it.err});
                check(route_mask == 32'hFFF, "R8", "route_mask", route_mask, 32'hFFF);
                check(!up_ready, "R11", "up_ready while held", {31'b0, up_ready}, 0);
                if (left > 0) begin
                    // R9: other ports ready, selected one not; request must stay.
                    down_ready = ~expv;
                    left--;
                end else begin
                    down_ready = expv;
                    left = -1;
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(up_ready == 1'b1, "R1", "up_ready", {31'b0, up_ready}, 1);
        check(down_valid == 3'b0, "R1", "down_valid", {29'b0, down_valid}, 0);
        check(cfg_err == 1'b0, "R1", "cfg_err", {31'b0, cfg_err}, 0);
        // R6: lines low -> in-window goes to port 0
        send(32'h0001_0000, 0, "R6");
        send(32'h0001_1004, 1, "R6");
        // R7: only highest line
        en_lines = 16'h8000; repeat (2) @(negedge clk);
        send(32'h0001_0010, 0, "R2");
        send(32'h0001_1010, 2, "R3");
        // R7: only lowest line
        en_lines = 16'h0001; repeat (2) @(negedge clk);
        send(32'h0001_2abc, 0, "R7");
        send(32'h0001_3ffc, 3, "R7");
        // R7: clearing the line drops back to bypass
        en_lines = 16'h0000; repeat (2) @(negedge clk);
        send(32'h0001_2000, 0, "R7");
        en_lines = 16'h0420; repeat (2) @(negedge clk);
        // R4 outside window
        send(32'h0000_1000, 0, "R4");
        send(32'h8000_1000, 1, "R4");
        // R12 boundaries
        send(BASE, 0, "R12");
        send(BASE - 1, 0, "R12");
        send(LIM, 0, "R12");
        send(ALIM - 4, 0, "R12");
        // R10 mismatch region
        send(32'h0001_8000, 2, "R10");
        send(32'h0001_F000, 0, "R10");
        // R9 long stall on striped port
        send(32'h0001_5000, 6, "R9");
        repeat (3) @(negedge clk);
        check(up_ready == 1'b1 && down_valid == 3'b0, "R11", "idle after drain",
              {29'b0, down_valid}, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule